// File: doc/BRIEF.md
# Parity Product Code Receive Corrector

This block sits at the receiving end of an on-chip link whose traffic is protected by a two-dimensional parity code. Each coded flit carries a data word plus one even-parity bit. A group is a fixed number of data flits followed by one parity flit, and every bit of that parity flit is the XOR of the same bit position across the data flits. As flits arrive, the block checks each one against its own parity bit and keeps one row syndrome bit per data flit. It also keeps a running XOR across the whole group, which gives one column syndrome bit per bit index. The data flits are buffered while this happens.

When the parity flit has been taken, the two syndromes settle the outcome:

- **Clean group:** the buffered flits are released unchanged.
- **Single upset:** exactly one flit and exactly one bit index are flagged. The buffered flits are released with that one bit inverted on the way out.
- **Any other pattern:** the group is dropped. A one-cycle retransmission request is raised, carrying the column syndrome as a mask of the failing bit indexes.

Two group buffers let the next group stream in while the previous one drains through a valid/ready output.

Top module: `ppc_rx_corrector`

## Requirements
- R1: After reset `in_ready` is 1, and both `out_valid` and `req_valid` are 0.
- R2: A coded flit holds its data in `in_flit[DATA_W-1:0]` and its parity bit in `in_flit[DATA_W]`. Its row syndrome is the XOR of all DATA_W+1 bits, where 1 means an upset. An even number of flips inside one flit leaves that syndrome at 0.
- R3: A group is GRP_FLITS data flits followed by one parity flit. Bit i of the column syndrome is the XOR of bit i of all GRP_FLITS+1 accepted flits, for i from 0 to DATA_W. An upset in the parity flit alone is therefore seen as column bits with no row bit.
- R4: When both syndromes are all zero, the group's data words are output unchanged, in arrival order.
- R5: When exactly one row bit and exactly one column bit below DATA_W are set, the data word of that flit is output with that bit inverted. The other words are output unchanged and no request is raised.
- R6: When exactly one row bit is set and the only column bit set is index DATA_W, all data words are output unchanged and no request is raised.
- R7: Every other syndrome pattern has the following effect:
  - `req_valid` is high for exactly one cycle, the cycle after the parity flit is accepted.
  - `req_mask` equals the DATA_W+1-bit column syndrome during that cycle.
  - None of the group's words are output.
- R8: A flit is accepted only on a cycle with `in_valid` and `in_ready` both high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R9: `in_ready` is low exactly when two complete groups are held whose last word has not yet been taken.
- R10: If no earlier group is still held, the first word of a clean or corrected group is offered on the cycle after its parity flit is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Coded flit present |
| in_ready | output | 1 | Block can accept a coded flit |
| in_flit | input | DATA_W+1 | Coded flit: parity bit on top, data below |
| out_valid | output | 1 | Corrected data word present |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | DATA_W | Corrected data word |
| req_valid | output | 1 | One-cycle retransmission request |
| req_mask | output | DATA_W+1 | Failing bit indexes (column syndrome) |

## Verification
The assertions assume that the sender frames its traffic exactly: every group is GRP_FLITS data flits followed by one parity flit, with no partial group left at reset. Under that framing, any write into a buffer that is still held counts as a real overrun. The stimulus always pushes whole groups and flips at most three bits per group. The upsets are placed to reach each syndrome class, including parity-bit and parity-flit upsets. A long output stall fills both buffers so that back-pressure is exercised.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  typedef enum logic [1:0] {
    GRP_CLEAN = 2'd0,
    GRP_FIX   = 2'd1,
    GRP_RETRY = 2'd2
  } grp_verdict_e;
endpackage

// File: rtl/ppc_row_parity.sv
module ppc_row_parity #(
  parameter int WIDTH = 17
) (
  input  logic [WIDTH-1:0] flit,
  output logic             upset
);
  // even parity over data and its parity bit
  assign upset = ^flit;
endmodule

// File: rtl/ppc_syndrome_acc.sv
module ppc_syndrome_acc
  import ppc_pkg::*;
#(
  parameter  int DATA_W    = 16,
  parameter  int GRP_FLITS = 4,
  localparam int SLOT_W    = $clog2(GRP_FLITS),
  localparam int POS_W     = $clog2(GRP_FLITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic [DATA_W:0]      flit,
  input  logic                 row_err,
  output logic                 wr_en,
  output logic [SLOT_W-1:0]    wr_idx,
  output logic                 grp_done,
  output grp_verdict_e         verdict,
  output logic [GRP_FLITS-1:0] err_rows,
  output logic [DATA_W:0]      col_vec
);
  logic [POS_W-1:0]     pos_q, pos_d;
  logic [GRP_FLITS-1:0] row_q, row_d;
  logic [DATA_W:0]      col_q, col_d;
  logic                 at_parity;
  int                   row_cnt;
  int                   col_cnt;

  assign at_parity = (pos_q == POS_W'(GRP_FLITS));
  assign wr_en     = take && !at_parity;
  assign wr_idx    = pos_q[SLOT_W-1:0];
  assign grp_done  = take && at_parity;
  assign col_vec   = col_q ^ flit;
  assign err_rows  = row_q;

  always_comb begin
    pos_d = pos_q;
    row_d = row_q;
    col_d = col_q;
    if (take) begin
      if (at_parity) begin
        pos_d = '0;
      end else begin
        pos_d = pos_q + 1'b1;
        if (pos_q == '0) begin
          row_d = '0;
          col_d = flit;
        end else begin
          col_d = col_q ^ flit;
        end
        row_d[pos_q[SLOT_W-1:0]] = row_err;
      end
    end
  end

  always_comb begin
    row_cnt = $countones(row_q);
    col_cnt = $countones(col_vec);
    if (row_cnt == 0 && col_cnt == 0)      verdict = GRP_CLEAN;
    else if (row_cnt == 1 && col_cnt == 1) verdict = GRP_FIX;
    else                                   verdict = GRP_RETRY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      row_q <= '0;
      col_q <= '0;
    end else begin
      pos_q <= pos_d;
      row_q <= row_d;
      col_q <= col_d;
    end
  end
endmodule

// File: rtl/ppc_bank_store.sv
module ppc_bank_store #(
  parameter  int DATA_W    = 16,
  parameter  int GRP_FLITS = 4,
  localparam int SLOT_W    = $clog2(GRP_FLITS),
  localparam int BANKS     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SLOT_W-1:0]    wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 commit,
  input  logic [GRP_FLITS-1:0] commit_rows,
  input  logic [DATA_W-1:0]    commit_mask,
  input  logic                 out_ready,
  output logic                 space_ok,
  output logic                 out_valid,
  output logic [DATA_W-1:0]    out_data
);
  logic [BANKS-1:0]  full_q, full_d;
  logic              wr_bank_q, wr_bank_d;
  logic              rd_bank_q, rd_bank_d;
  logic [SLOT_W-1:0] rd_idx_q, rd_idx_d;
  logic              pop, pop_last;
  logic [DATA_W-1:0] bank_word [BANKS];
  logic [DATA_W-1:0] bank_mask [BANKS];
  logic [BANKS-1:0]  bank_hit;
  logic [DATA_W-1:0] raw_word;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0]    slot_q [GRP_FLITS];
    logic [GRP_FLITS-1:0] rows_q;
    logic [DATA_W-1:0]    mask_q;
    logic                 sel_wr;
    assign sel_wr = (wr_bank_q == 1'(b));
    always_ff @(posedge clk) begin
      if (wr_en && sel_wr) slot_q[wr_idx] <= wr_data;
      if (commit && sel_wr) begin
        rows_q <= commit_rows;
        mask_q <= commit_mask;
      end
    end
    assign bank_word[b] = slot_q[rd_idx_q];
    assign bank_hit[b]  = rows_q[rd_idx_q];
    assign bank_mask[b] = mask_q;
  end

  assign space_ok  = !full_q[wr_bank_q];
  assign out_valid = full_q[rd_bank_q];
  assign raw_word  = bank_word[rd_bank_q];
  assign out_data  = raw_word ^ (bank_hit[rd_bank_q] ? bank_mask[rd_bank_q] : '0);
  assign pop       = out_valid && out_ready;
  assign pop_last  = pop && (rd_idx_q == SLOT_W'(GRP_FLITS - 1));

  always_comb begin
    full_d    = full_q;
    wr_bank_d = wr_bank_q;
    rd_bank_d = rd_bank_q;
    rd_idx_d  = rd_idx_q;
    if (commit) begin
      full_d[wr_bank_q] = 1'b1;
      wr_bank_d         = ~wr_bank_q;
    end
    if (pop_last) begin
      full_d[rd_bank_q] = 1'b0;
      rd_bank_d         = ~rd_bank_q;
      rd_idx_d          = '0;
    end else if (pop) begin
      rd_idx_d = rd_idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q    <= '0;
      wr_bank_q <= 1'b0;
      rd_bank_q <= 1'b0;
      rd_idx_q  <= '0;
    end else begin
      full_q    <= full_d;
      wr_bank_q <= wr_bank_d;
      rd_bank_q <= rd_bank_d;
      rd_idx_q  <= rd_idx_d;
    end
  end

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R5
  fix_single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_data ^ raw_word) <= 1);

  // R9
  wr_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || commit) |-> !full_q[wr_bank_q]);
endmodule

// File: rtl/ppc_rx_corrector.sv
module ppc_rx_corrector
  import ppc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int GRP_FLITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W:0]   in_flit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              req_valid,
  output logic [DATA_W:0]   req_mask
);
  localparam int FLIT_W = DATA_W + 1;
  localparam int SLOT_W = $clog2(GRP_FLITS);

  logic [1:0]           rst_pipe_q;
  logic                 rst_core_n;
  logic                 take;
  logic                 row_err;
  logic                 wr_en;
  logic [SLOT_W-1:0]    wr_idx;
  logic                 grp_done;
  grp_verdict_e         verdict;
  logic [GRP_FLITS-1:0] err_rows;
  logic [DATA_W:0]      col_vec;
  logic                 commit;
  logic                 req_valid_q, req_valid_d;
  logic [DATA_W:0]      req_mask_q, req_mask_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  assign take   = in_valid && in_ready;
  assign commit = grp_done && (verdict != GRP_RETRY);

  ppc_row_parity #(.WIDTH(FLIT_W)) u_row (
    .flit  (in_flit),
    .upset (row_err)
  );

  ppc_syndrome_acc #(.DATA_W(DATA_W), .GRP_FLITS(GRP_FLITS)) u_acc (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .take     (take),
    .flit     (in_flit),
    .row_err  (row_err),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .grp_done (grp_done),
    .verdict  (verdict),
    .err_rows (err_rows),
    .col_vec  (col_vec)
  );

  ppc_bank_store #(.DATA_W(DATA_W), .GRP_FLITS(GRP_FLITS)) u_store (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (in_flit[DATA_W-1:0]),
    .commit      (commit),
    .commit_rows (err_rows),
    .commit_mask (col_vec[DATA_W-1:0]),
    .out_ready   (out_ready),
    .space_ok    (in_ready),
    .out_valid   (out_valid),
    .out_data    (out_data)
  );

  always_comb begin
    req_valid_d = grp_done && (verdict == GRP_RETRY);
    req_mask_d  = req_valid_d ? col_vec : req_mask_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      req_valid_q <= 1'b0;
      req_mask_q  <= '0;
    end else begin
      req_valid_q <= req_valid_d;
      req_mask_q  <= req_mask_d;
    end
  end

  assign req_valid = req_valid_q;
  assign req_mask  = req_mask_q;

  // R7
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    req_valid |=> !req_valid);
endmodule

// File: tb/ppc_rx_corrector_test.sv
module ppc_rx_corrector_test;
  localparam int N = 16;
  localparam int M = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [N:0]   in_flit;
  logic         out_valid;
  logic         out_ready;
  logic [N-1:0] out_data;
  logic         req_valid;
  logic [N:0]   req_mask;

  always #5 clk = ~clk;

  ppc_rx_corrector #(.DATA_W(N), .GRP_FLITS(M)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_flit(in_flit), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .req_valid(req_valid), .req_mask(req_mask)
  );

  int           checks = 0;
  int           fails  = 0;
  logic [N:0]   in_q  [$];
  logic [N:0]   grp   [$];
  logic [N-1:0] exp_q [$];
  string        tag_q [$];
  int           pend = 0;
  int           taken_in_grp = 0;
  bit           exp_req_nxt = 0;
  logic [N:0]   exp_mask_nxt = '0;
  bit           exp_ov_nxt = 0;
  bit           prev_hold = 0;
  logic [N-1:0] prev_data = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [N:0] act, input logic [N:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // push one group; r = flit index (M is the parity flit), c = bit index, -1 = no flip
  task automatic add_group(input int r0, input int c0, input int r1, input int c1,
                           input int r2, input int c2);
    logic [N:0] f [M+1];
    logic [N:0] fp = '0;
    for (int i = 0; i < M; i++) begin
      f[i][N-1:0] = N'($urandom);
      f[i][N]     = ^f[i][N-1:0];
      fp          = fp ^ f[i];
    end
    f[M] = fp;
    if (r0 >= 0) f[r0][c0] = ~f[r0][c0];
    if (r1 >= 0) f[r1][c1] = ~f[r1][c1];
    if (r2 >= 0) f[r2][c2] = ~f[r2][c2];
    for (int i = 0; i <= M; i++) in_q.push_back(f[i]);
  endtask

  task automatic model_group();
    logic [N:0]   col = '0;
    int           rc = 0;
    int           ri = -1;
    int           cc;
    int           ci = -1;
    logic [N-1:0] d;
    for (int i = 0; i <= M; i++) col = col ^ grp[i];
    for (int i = 0; i < M; i++) if (^grp[i]) begin rc++; ri = i; end
    cc = $countones(col);
    for (int j = 0; j <= N; j++) if (col[j]) ci = j;
    if ((rc == 0 && cc == 0) || (rc == 1 && cc == 1)) begin
      for (int i = 0; i < M; i++) begin
        d = grp[i][N-1:0];
        if (rc == 1 && i == ri && ci < N) d[ci] = ~d[ci];
        exp_q.push_back(d);
        if (rc == 0)     tag_q.push_back("R4");
        else if (ci < N) tag_q.push_back("R2 R5");
        else             tag_q.push_back("R6");
      end
      pend++;
      if (pend == 1) exp_ov_nxt = 1;
    end else begin
      exp_req_nxt  = 1;
      exp_mask_nxt = col;
    end
    grp.delete();
  endtask

  initial begin
    int  cyc;
    bit  acc_in;
    bit  take_out;
    logic [N-1:0] d;
    string t;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_flit   = '0;
    out_ready = 1'b0;

    add_group(-1, 0, -1, 0, -1, 0);          // clean
    add_group(-1, 0, -1, 0, -1, 0);
    add_group(1, 5, -1, 0, -1, 0);           // single data bit
    add_group(2, N, -1, 0, -1, 0);           // parity bit of a data flit
    add_group(M, 3, -1, 0, -1, 0);           // parity flit only (R3)
    add_group(0, 2, 0, 9, -1, 0);            // even flips in one flit (R2)
    add_group(1, 7, 3, 7, -1, 0);            // same column, two flits
    add_group(2, 1, 2, 4, 2, 11);            // three flips in one flit
    add_group(0, 0, -1, 0, -1, 0);           // first bit of first flit
    add_group(M-1, N-1, -1, 0, -1, 0);       // last data bit of last flit
    add_group(0, 1, 1, 2, -1, 0);            // two rows, two columns
    add_group(M, N, -1, 0, -1, 0);           // parity bit of parity flit
    for (int g = 0; g < 40; g++) begin
      if (g % 3 == 0) add_group(-1, 0, -1, 0, -1, 0);
      else add_group(int'($urandom_range(0, M-1)), int'($urandom_range(0, N)), -1, 0, -1, 0);
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", {16'b0, in_ready}, 17'd1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", {16'b0, out_valid}, 17'd0);
    chk(req_valid == 1'b0, "R1", "req_valid after reset", {16'b0, req_valid}, 17'd0);

    cyc = 0;
    while ((in_q.size() != 0 || exp_q.size() != 0 || grp.size() != 0 || exp_req_nxt)
           && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      // per-cycle comparisons against the reference model
      chk(req_valid == exp_req_nxt, "R7", "req_valid", {16'b0, req_valid}, {16'b0, exp_req_nxt});
      if (exp_req_nxt) chk(req_mask == exp_mask_nxt, "R3 R7", "req_mask", req_mask, exp_mask_nxt);
      exp_req_nxt = 0;
      chk(in_ready == (pend < 2), "R9", "in_ready", {16'b0, in_ready}, {16'b0, pend < 2});
      if (out_valid) chk(exp_q.size() != 0, "R7", "word offered with none expected",
                         {1'b0, out_data}, '0);
      if (exp_ov_nxt) chk(out_valid == 1'b1, "R10", "out_valid after parity flit",
                          {16'b0, out_valid}, 17'd1);
      exp_ov_nxt = 0;
      if (prev_hold) chk(out_valid && out_data == prev_data, "R8", "held word",
                         {out_valid, out_data}, {1'b1, prev_data});

      // drive inputs for the next edge
      if (cyc >= 100 && cyc < 160) out_ready = 1'b0;
      else out_ready = ($urandom_range(0, 3) != 0);
      in_valid = (in_q.size() != 0) && ($urandom_range(0, 4) != 0);
      in_flit  = in_valid ? in_q[0] : '0;

      acc_in   = in_valid && in_ready;
      take_out = out_valid && out_ready;
      if (take_out && exp_q.size() != 0) begin
        d = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_data == d, t, "out_data", {1'b0, out_data}, {1'b0, d});
        taken_in_grp++;
        if (taken_in_grp == M) begin
          taken_in_grp = 0;
          pend--;
        end
      end
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
      if (acc_in) begin
        grp.push_back(in_q.pop_front());
        if (grp.size() == M + 1) model_group();
      end
    end
    if (cyc >= 20000) begin
      fails++;
      $display("FAIL R9 watchdog: stream did not drain actual=%0d expected=0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule